// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the status and control word of one downstream root port in a USB host controller. Software sees it as a single 32-bit register. A simple port model drives the block through input pins: device presence, over-current, the negotiated speed and link-state transitions. The block holds the live port status and the software-owned control fields, and it keeps a set of sticky change flags that software clears by writing 1. It runs a short port-reset sequence with a programmable length and reports when that sequence completes. It also emits a single-cycle port-change pulse that feeds a controller-wide status summary.

Real link training, bus signalling and power switching are not modelled. Pins and a cycle-count reset timer stand in for them. Hardware events always win over a software write that lands in the same cycle.

Top module: `port_status_reg`

## Requirements
- R1: After reset, with the connect and over-current inputs low, the register reads 0x0000_0000 and the port-change output is low.
- R2: Bit 0 follows the connect input and bit 3 follows the over-current input, each one clock after the input changes.
- R3: Every edge of the connect input sets bit 17, the connect change flag. Every edge of the over-current input sets bit 20, the over-current change flag.
- R4: The change flags at bits 17, 18, 20, 21 and 22 clear only when software writes 1 to them. Writing 0 leaves a flag as it is, and reading never clears one. If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R5: Writing 1 to bit 4 while the port is connected (bit 0) and powered (bit 9) starts a port reset. Bit 4 then reads 1 for exactly RESET_CYCLES clocks. When it clears, bit 1 (enabled) becomes 1, bits 13:10 load the speed input (0 undefined, 1 full, 2 low, 3 high, 4 super) and bit 21 (reset change) becomes 1.
- R6: A write of 1 to bit 4 has no effect while the port is disconnected or unpowered.
- R7: When the connect input falls, bit 1 and bits 13:10 clear, and bits 17 and 18 (enable change) are set. A reset that is in progress is aborted. Bit 4 then falls and sets bit 21, but the port is not enabled.
- R8: A write with bit 16 (link-state strobe) set loads bits 8:5 from the written data. Without the strobe, bits 8:5 keep their value.
- R9: A link event from the port model loads bits 8:5 from the event state and sets bit 22 (link change). This takes priority over a strobed software write in the same cycle.
- R10: Bits 15:14 (indicator: 0 off, 1 amber, 2 green) are read/write. A write of the value 3 leaves the field unchanged.
- R11: Bit 9 (power) and bits 27:25 (wake on connect, disconnect, over-current) are read/write. Writes cannot change bits 0, 1, 3 or 13:10. Reserved bits 2, 19, 23, 24 and 31:28 read 0.
- R12: The port-change output pulses high for one clock, in the same cycle a change flag first reads 1, whenever at least one flag goes from 0 to 1. It stays low when a flag that is already set is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register value |
| phy_connect_i | input | 1 | Device present on the port |
| phy_overcurrent_i | input | 1 | Over-current condition from the port |
| phy_speed_i | input | 4 | Speed code captured at reset completion |
| link_evt_i | input | 1 | One-cycle hardware link-state transition |
| link_evt_state_i | input | 4 | New link state carried by the event |
| port_change_o | output | 1 | One-cycle pulse when any change flag rises |

## Verification
The assertions assume that the port-model inputs are synchronous to clk and stable around the edge. They also assume that a link event is a single-cycle pulse, and that writes are one-cycle strobes with no read side effects. The stimulus changes every input and write strobe only on the falling clock edge. It holds each write for exactly one cycle, and it keeps the connect and over-current inputs low through reset, so the edge detectors start from a known level. Write data always carries the current power, wake and indicator settings, so that only the field under test changes.

// File: rtl/psc_pkg.sv
package psc_pkg;
    // register bit positions
    localparam int B_CONN   = 0;
    localparam int B_EN     = 1;
    localparam int B_OC     = 3;
    localparam int B_RST    = 4;
    localparam int B_LS_LO  = 5;
    localparam int B_PWR    = 9;
    localparam int B_SPD_LO = 10;
    localparam int B_IND_LO = 14;
    localparam int B_STROBE = 16;
    localparam int B_CSC    = 17;
    localparam int B_PEC    = 18;
    localparam int B_OCC    = 20;
    localparam int B_PRC    = 21;
    localparam int B_PLC    = 22;
    localparam int B_WAKE_LO = 25;

    localparam int LS_W   = 4;
    localparam int SPD_W  = 4;
    localparam int WAKE_W = 3;

    // change flag vector indices
    localparam int NFLAGS  = 5;
    localparam int F_CONN  = 0;
    localparam int F_EN    = 1;
    localparam int F_OC    = 2;
    localparam int F_RST   = 3;
    localparam int F_LINK  = 4;

    typedef enum logic [1:0] {
        IND_OFF   = 2'd0,
        IND_AMBER = 2'd1,
        IND_GREEN = 2'd2,
        IND_RSVD  = 2'd3
    } ind_e;

    typedef struct packed {
        logic              enable;
        logic              power;
        logic [LS_W-1:0]   link;
        logic [SPD_W-1:0]  speed;
        ind_e              ind;
        logic [WAKE_W-1:0] wake;
    } ctl_t;
endpackage

// File: rtl/psc_edge_detect.sv
module psc_edge_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d  = in_i;
        rise_o = in_i & ~lvl_q;
        fall_o = ~in_i & lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign level_o = lvl_q;

    // R2: the registered level tracks the input one clock later
    p_level_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q == $past(in_i)));
endmodule

// File: rtl/psc_reset_timer.sv
module psc_reset_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic active_o,
    output logic done_o,
    output logic ended_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        done_o  = 1'b0;
        ended_o = 1'b0;
        if (tmr_q.active) begin
            if (abort_i) begin
                tmr_d.active = 1'b0;
                tmr_d.cnt    = '0;
                ended_o      = 1'b1;
            end else if (tmr_q.cnt == CW'(1)) begin
                tmr_d.active = 1'b0;
                tmr_d.cnt    = '0;
                done_o       = 1'b1;
                ended_o      = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end else if (start_i && !abort_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = CW'(CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active_o = tmr_q.active;

    // R5: while running, the count stays within 1..CYCLES
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active |-> (tmr_q.cnt != '0 && tmr_q.cnt <= CW'(CYCLES)));
    // R5: a fresh start loads the full length
    p_start_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.active) |-> (tmr_q.cnt == CW'(CYCLES)));
endmodule

// File: rtl/psc_change_flags.sv
module psc_change_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o,
    output logic         pulse_o
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic         pulse;
    } fl_t;

    fl_t fl_d, fl_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // hardware set has priority over a write-1 clear
        assign fl_d.flags[i] = set_i[i] | (fl_q.flags[i] & ~clr_i[i]);

        // R4: a flag only falls after a write-1 to it
        p_clear_only_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fl_q.flags[i]) |-> $past(clr_i[i]));
    end

    always_comb begin
        fl_d.pulse = |(fl_d.flags & ~fl_q.flags);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q.flags;
    assign pulse_o = fl_q.pulse;

    // R12: a pulse coincides with at least one flag newly set
    p_pulse_on_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.pulse |-> ((fl_q.flags & ~$past(fl_q.flags)) != '0));
endmodule

// File: rtl/port_status_reg.sv
module port_status_reg
    import psc_pkg::*;
#(
    parameter int RESET_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    input  logic        phy_connect_i,
    input  logic        phy_overcurrent_i,
    input  logic [3:0]  phy_speed_i,
    input  logic        link_evt_i,
    input  logic [3:0]  link_evt_state_i,
    output logic        port_change_o
);
    localparam int IDX_CONN = 0;
    localparam int IDX_OC   = 1;

    ctl_t ctl_d, ctl_q;

    logic [1:0] lvl, rise, fall;
    logic       conn_fall;
    logic       rst_active, rst_done, rst_ended, rst_start;
    logic [NFLAGS-1:0] flag_set, flag_clr, flags;
    ind_e       wr_ind;

    psc_edge_detect #(.W(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_i    ({phy_overcurrent_i, phy_connect_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign conn_fall = fall[IDX_CONN];

    assign rst_start = wr_en_i && wr_data_i[B_RST] && lvl[IDX_CONN] && ctl_q.power;

    psc_reset_timer #(.CYCLES(RESET_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rst_start),
        .abort_i  (conn_fall),
        .active_o (rst_active),
        .done_o   (rst_done),
        .ended_o  (rst_ended)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[F_CONN]  = rise[IDX_CONN] | fall[IDX_CONN];
        flag_set[F_EN]    = conn_fall;
        flag_set[F_OC]    = rise[IDX_OC] | fall[IDX_OC];
        flag_set[F_RST]   = rst_ended;
        flag_set[F_LINK]  = link_evt_i;

        flag_clr          = '0;
        if (wr_en_i) begin
            flag_clr[F_CONN] = wr_data_i[B_CSC];
            flag_clr[F_EN]   = wr_data_i[B_PEC];
            flag_clr[F_OC]   = wr_data_i[B_OCC];
            flag_clr[F_RST]  = wr_data_i[B_PRC];
            flag_clr[F_LINK] = wr_data_i[B_PLC];
        end
    end

    psc_change_flags #(.N(NFLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags),
        .pulse_o (port_change_o)
    );

    assign wr_ind = ind_e'(wr_data_i[B_IND_LO +: 2]);

    always_comb begin
        ctl_d = ctl_q;
        // software-owned fields
        if (wr_en_i) begin
            ctl_d.power = wr_data_i[B_PWR];
            ctl_d.wake  = wr_data_i[B_WAKE_LO +: WAKE_W];
            if (wr_ind != IND_RSVD)
                ctl_d.ind = wr_ind;
            if (wr_data_i[B_STROBE])
                ctl_d.link = wr_data_i[B_LS_LO +: LS_W];
        end
        // hardware events override software
        if (link_evt_i)
            ctl_d.link = link_evt_state_i;
        if (rst_done) begin
            ctl_d.enable = 1'b1;
            ctl_d.speed  = phy_speed_i;
        end
        if (conn_fall) begin
            ctl_d.enable = 1'b0;
            ctl_d.speed  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{enable: 1'b0, power: 1'b0, link: '0, speed: '0,
                               ind: IND_OFF, wake: '0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data_o                          = '0;
        rd_data_o[B_CONN]                  = lvl[IDX_CONN];
        rd_data_o[B_EN]                    = ctl_q.enable;
        rd_data_o[B_OC]                    = lvl[IDX_OC];
        rd_data_o[B_RST]                   = rst_active;
        rd_data_o[B_LS_LO +: LS_W]         = ctl_q.link;
        rd_data_o[B_PWR]                   = ctl_q.power;
        rd_data_o[B_SPD_LO +: SPD_W]       = ctl_q.speed;
        rd_data_o[B_IND_LO +: 2]           = ctl_q.ind;
        rd_data_o[B_CSC]                   = flags[F_CONN];
        rd_data_o[B_PEC]                   = flags[F_EN];
        rd_data_o[B_OCC]                   = flags[F_OC];
        rd_data_o[B_PRC]                   = flags[F_RST];
        rd_data_o[B_PLC]                   = flags[F_LINK];
        rd_data_o[B_WAKE_LO +: WAKE_W]     = ctl_q.wake;
    end

    // R5: a completed reset enables the port with the sampled speed
    p_done_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (ctl_q.enable && ctl_q.speed == $past(phy_speed_i)));
    // R5: the reset bit falling always raises the reset change flag
    p_rst_fall_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> flags[F_RST]);
    // R7: disconnect clears enable and speed and raises both change flags
    p_disc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conn_fall |=> (!ctl_q.enable && ctl_q.speed == '0 &&
                       flags[F_CONN] && flags[F_EN] && !rst_active));
    // R8: without strobe or event the link state holds
    p_link_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_evt_i && !(wr_en_i && wr_data_i[B_STROBE])) |=> $stable(ctl_q.link));
    // R10: the indicator never holds the reserved code
    p_ind_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.ind != IND_RSVD);
endmodule

// File: tb/port_status_reg_tb_top.sv
`timescale 1ns/1ps
module port_status_reg_tb_top;
    localparam int RCYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd;
    logic        conn = 1'b0, oc = 1'b0;
    logic [3:0]  speed = 4'd3;
    logic        levt = 1'b0;
    logic [3:0]  lstate = '0;
    logic        pchg;

    int tests = 0;
    int fails = 0;
    logic [31:0] base = 32'h0000_0200; // power on, kept in every write

    always #5 clk = ~clk;

    port_status_reg #(.RESET_CYCLES(RCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd), .phy_connect_i(conn), .phy_overcurrent_i(oc),
        .phy_speed_i(speed), .link_evt_i(levt), .link_evt_state_i(lstate),
        .port_change_o(pchg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        wr(base | 32'h0076_0000);
    endtask

    task automatic t_reset_state();
        check("R1 reg", rd, 32'h0);
        check("R1 pulse", {31'b0, pchg}, 32'h0);
    endtask

    task automatic t_live_change();
        wr(base);
        conn = 1'b1; step();
        check("R2 conn bit", {31'b0, rd[0]}, 32'h1);
        check("R3 csc", {31'b0, rd[17]}, 32'h1);
        check("R12 pulse on rise", {31'b0, pchg}, 32'h1);
        step();
        check("R12 pulse one cycle", {31'b0, pchg}, 32'h0);
        oc = 1'b1; step();
        check("R2 oc bit", {31'b0, rd[3]}, 32'h1);
        check("R3 occ", {31'b0, rd[20]}, 32'h1);
        check("R12 pulse oc", {31'b0, pchg}, 32'h1);
        oc = 1'b0; step();
        check("R12 no pulse when already set", {31'b0, pchg}, 32'h0);
        check("R2 oc low", {31'b0, rd[3]}, 32'h0);
    endtask

    task automatic t_w1c();
        wr(base);
        check("R4 write 0 keeps", {30'b0, rd[20], rd[17]}, 32'h3);
        step(); step();
        check("R4 read keeps", {30'b0, rd[20], rd[17]}, 32'h3);
        wr(base | (32'h1 << 17));
        check("R4 w1c clears csc", {30'b0, rd[20], rd[17]}, 32'h2);
        // clear OCC while over-current toggles in the same cycle
        oc = 1'b1;
        wr(base | (32'h1 << 20));
        check("R4 set beats clear", {31'b0, rd[20]}, 32'h1);
        check("R12 no pulse on re-set", {31'b0, pchg}, 32'h0);
        oc = 1'b0; step();
        clear_all();
        check("R4 all cleared", rd & 32'h0076_0000, 32'h0);
    endtask

    task automatic t_port_reset();
        int n = 0;
        speed = 4'd3;
        wr(base | 32'h10);
        while (rd[4] && n < 1000) begin n++; step(); end
        check("R5 reset length", n, RCYC);
        check("R5 enabled", {31'b0, rd[1]}, 32'h1);
        check("R5 speed latched", {28'b0, rd[13:10]}, 32'h3);
        check("R5 prc", {31'b0, rd[21]}, 32'h1);
        check("R12 pulse on prc", {31'b0, pchg}, 32'h1);
        clear_all();
    endtask

    task automatic t_reset_refused();
        conn = 1'b0; step();
        clear_all();
        wr(base | 32'h10);
        check("R6 no reset when disconnected", {31'b0, rd[4]}, 32'h0);
        conn = 1'b1; step();
        base = 32'h0;
        wr(base);
        wr(base | 32'h10);
        check("R6 no reset when unpowered", {31'b0, rd[4]}, 32'h0);
        base = 32'h0000_0200;
        wr(base);
        clear_all();
    endtask

    task automatic t_disconnect();
        // port connected and enabled from the earlier reset
        check("R7 precondition enabled", {31'b0, rd[1]}, 32'h1);
        conn = 1'b0; step();
        check("R7 enable cleared", {31'b0, rd[1]}, 32'h0);
        check("R7 speed cleared", {28'b0, rd[13:10]}, 32'h0);
        check("R7 csc and pec", {30'b0, rd[18], rd[17]}, 32'h3);
        check("R12 pulse disconnect", {31'b0, pchg}, 32'h1);
        conn = 1'b1; step();
        clear_all();
        wr(base | 32'h10);
        step(); step();
        check("R5 reset running", {31'b0, rd[4]}, 32'h1);
        conn = 1'b0; step();
        check("R7 abort reset bit", {31'b0, rd[4]}, 32'h0);
        check("R7 abort prc", {31'b0, rd[21]}, 32'h1);
        check("R7 abort not enabled", {31'b0, rd[1]}, 32'h0);
        step(); step();
        check("R7 stays disabled", {31'b0, rd[1]}, 32'h0);
        clear_all();
    endtask

    task automatic t_link();
        wr(base | (32'h1 << 16) | (32'd5 << 5));
        check("R8 strobe write", {28'b0, rd[8:5]}, 32'h5);
        check("R8 no plc from sw", {31'b0, rd[22]}, 32'h0);
        wr(base | (32'd7 << 5));
        check("R8 no strobe ignored", {28'b0, rd[8:5]}, 32'h5);
        levt = 1'b1; lstate = 4'd3; step();
        levt = 1'b0;
        check("R9 hw event state", {28'b0, rd[8:5]}, 32'h3);
        check("R9 plc", {31'b0, rd[22]}, 32'h1);
        check("R12 pulse link", {31'b0, pchg}, 32'h1);
        levt = 1'b1; lstate = 4'd2;
        wr(base | (32'h1 << 16) | (32'd9 << 5));
        levt = 1'b0;
        check("R9 hw beats sw", {28'b0, rd[8:5]}, 32'h2);
        clear_all();
    endtask

    task automatic t_ctl_fields();
        base = 32'h0000_0200 | (32'd2 << 14);
        wr(base);
        check("R10 indicator green", {30'b0, rd[15:14]}, 32'h2);
        wr(32'h0000_0200 | (32'd3 << 14));
        check("R10 value 3 ignored", {30'b0, rd[15:14]}, 32'h2);
        base = base | (32'h7 << 25);
        wr(base | 32'h0000_3C0A | 32'hF188_0004);
        check("R11 wake bits", {29'b0, rd[27:25]}, 32'h7);
        check("R11 power", {31'b0, rd[9]}, 32'h1);
        check("R11 ro bits", {26'b0, rd[13:10], rd[3], rd[1]}, 32'h0);
        check("R11 reserved zero", rd & 32'hF188_0004, 32'h0);
        base = 32'h0;
        wr(base);
        check("R11 power and wake clear", {28'b0, rd[27:25], rd[9]}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_live_change();
        t_w1c();
        t_port_reset();
        t_reset_refused();
        t_port_reset();
        t_disconnect();
        t_link();
        t_ctl_fields();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule